// File: doc/BRIEF.md
# Return-from-Interrupt Bus Cycle Generator

This block generates the I/O-bus transaction that signals an interrupt return to peripherals on a priority daisy chain. A single-cycle start request from the core launches the transaction. The block then steps through a fixed sequence of ten I/O clock periods. During that sequence it drives the two opcode bytes of the return instruction onto the data bus. It also drives the active-low fetch, I/O-request and I/O-read strobes, so that each peripheral sees two back-to-back opcode fetches.

An active-low wait input is sampled on the falling I/O clock edge at three points in the sequence:

- In cycle 3, so that a slow peripheral can lengthen the read strobe.
- In cycle 5, which falls between the two fetches. This gives the peripheral's internal chain time to settle.
- In cycle 9, again to lengthen the read strobe.

Each sample that finds wait low repeats the current cycle once. When the last cycle ends, the block raises a one-clock done pulse to the core.

Top module: `reti_cycle_gen`

## Requirements
- R1: After reset, busy, done and data_oe are low, data_out is 0, and all five strobes are high.
- R2: A start seen high on a rising edge while idle begins the sequence at cycle 1. With wait_n held high, busy stays high for exactly 10 clocks. The clock after busy falls carries done=1 for exactly one clock.
- R3: Cycles other than 3, 5 and 9 always advance on the next rising edge, whatever the level of wait_n.
- R4: When wait_n is low at the falling edge inside cycle 3, cycle 3 repeats for one more clock. Each further low sample adds one more clock.
- R5: When wait_n is low at the falling edge inside cycle 5, cycle 5 repeats in the same way. The strobes stay high during every repetition.
- R6: When wait_n is low at the falling edge inside cycle 9, cycle 9 repeats in the same way, and the strobes stay low.
- R7: data_oe is high throughout busy. data_out is 16'hEDED in cycles 1 to 5 and 16'h4D4D in cycles 6 to 10.
- R8: fetch_n, ioreq_n and iord_n are low exactly in cycles 2 to 4 and 7 to 9, and high otherwise, including while idle.
- R9: iowr_n and intack_n stay high at all times.
- R10: A start pulse while busy has no effect on the cycle sequence or the total length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request from the core |
| wait_n | input | 1 | Active-low wait, sampled on the falling edge |
| data_out | output | 16 | Data bus value |
| data_oe | output | 1 | Data bus drive enable |
| fetch_n | output | 1 | Active-low opcode fetch indicator |
| ioreq_n | output | 1 | Active-low I/O request |
| iord_n | output | 1 | Active-low I/O read |
| iowr_n | output | 1 | Active-low I/O write, held inactive |
| intack_n | output | 1 | Active-low interrupt acknowledge, held inactive |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench sweeps zero to two wait clocks at each of the three sample points, in every combination. It checks the total length and the data and strobe values in every clock.

Each combination is also rerun with wait_n pulled low in all the non-sample cycles. That catches a design which stalls on any low wait, or which samples at the wrong cycle: it would lengthen runs that must stay at ten clocks.

Stalls at cycle 5 expose a design that keeps the strobes low across the gap, which would merge the two fetches. A start pulse issued mid-run catches a generator that restarts or re-arms while busy.

// File: rtl/reti_cycle_gen.sv
module reti_cycle_gen #(
  parameter logic [7:0] OP_HI = 8'hED,
  parameter logic [7:0] OP_LO = 8'h4D,
  parameter int         NCYC  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wait_n,
  output logic [15:0] data_out,
  output logic        data_oe,
  output logic        fetch_n,
  output logic        ioreq_n,
  output logic        iord_n,
  output logic        iowr_n,
  output logic        intack_n,
  output logic        busy,
  output logic        done
);
  localparam int         HALF = NCYC / 2;
  localparam logic [3:0] LAST = 4'(NCYC);

  logic [3:0] cyc;
  logic       hold;
  logic       samp_pt;
  logic       strobe_on;

  assign busy    = (cyc != 4'd0);
  assign samp_pt = (cyc == 4'd3) || (cyc == 4'(HALF)) || (cyc == 4'(NCYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= 4'd0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) cyc <= 4'd1;
      end else if (!hold) begin
        if (cyc == LAST) begin
          cyc  <= 4'd0;
          done <= 1'b1;
        end else begin
          cyc <= cyc + 4'd1;
        end
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= busy && samp_pt && !wait_n;
  end

  assign strobe_on = ((cyc >= 4'd2) && (cyc <= 4'(HALF - 1))) ||
                     ((cyc >= 4'(HALF + 2)) && (cyc <= 4'(NCYC - 1)));

  assign data_oe  = busy;
  assign data_out = !busy ? 16'h0000 :
                    (cyc <= 4'(HALF)) ? {OP_HI, OP_HI} : {OP_LO, OP_LO};
  assign fetch_n  = !strobe_on;
  assign ioreq_n  = !strobe_on;
  assign iord_n   = !strobe_on;
  assign iowr_n   = 1'b1;
  assign intack_n = 1'b1;
endmodule

module reti_cycle_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  cyc,
  input logic        hold,
  input logic        busy,
  input logic        done,
  input logic        data_oe,
  input logic [15:0] data_out,
  input logic        fetch_n,
  input logic        iord_n,
  input logic        iowr_n,
  input logic        intack_n
);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iowr_n && intack_n);

  p_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out == 16'hEDED || data_out == 16'h4D4D));

  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold && cyc != 4'd10) |=> (cyc == $past(cyc) + 4'd1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold) |=> $stable(cyc));

  p_hold_pt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (cyc == 4'd3 || cyc == 4'd5 || cyc == 4'd9));

  p_idle_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fetch_n && iord_n));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cyc != 4'd10) |=> busy);
endmodule

bind reti_cycle_gen reti_cycle_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cyc(cyc), .hold(hold),
  .busy(busy), .done(done), .data_oe(data_oe), .data_out(data_out),
  .fetch_n(fetch_n), .iord_n(iord_n), .iowr_n(iowr_n), .intack_n(intack_n)
);

// File: tb/reti_cycle_gen_test.sv
`timescale 1ns/100ps
module reti_cycle_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wait_n = 1'b1;
  logic [15:0] data_out;
  logic        data_oe, fetch_n, ioreq_n, iord_n, iowr_n, intack_n, busy, done;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  reti_cycle_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_n(wait_n),
    .data_out(data_out), .data_oe(data_oe), .fetch_n(fetch_n),
    .ioreq_n(ioreq_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .intack_n(intack_n), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input int w3, input int w5, input int w9, input bit noise, input bit kick);
    int ec = 1;
    int left3 = w3, left5 = w5, left9 = w9;
    int len = 0;
    bit low, strb;
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    while (ec <= 10) begin
      len++;
      strb = (ec >= 2 && ec <= 4) || (ec >= 7 && ec <= 9);
      check("R2 busy", {31'd0, busy}, 32'd1);
      check("R7 oe", {31'd0, data_oe}, 32'd1);
      check("R7 data", {16'd0, data_out}, (ec <= 5) ? 32'h0000EDED : 32'h00004D4D);
      check("R8 strobes", {29'd0, fetch_n, ioreq_n, iord_n}, strb ? 32'd0 : 32'd7);
      check("R9 idle strobes", {30'd0, iowr_n, intack_n}, 32'd3);
      if (ec == 3)      begin low = (left3 > 0); if (low) left3--; end
      else if (ec == 5) begin low = (left5 > 0); if (low) left5--; end
      else if (ec == 9) begin low = (left9 > 0); if (low) left9--; end
      else              low = noise;
      wait_n = !low;
      start = kick && (ec == 6);
      if (!(low && (ec == 3 || ec == 5 || ec == 9))) ec++;
      @(posedge clk); #1;
      start = 1'b0;
    end
    wait_n = 1'b1;
    check("R2 done", {30'd0, busy, done}, 32'd1);
    check("R4 R5 R6 length", len, 10 + w3 + w5 + w9);
    @(posedge clk); #1;
    check("R2 done pulse", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #12; 
    check("R1 reset", {busy, done, data_oe, fetch_n, ioreq_n, iord_n, iowr_n, intack_n, data_out}, {8'b00011111, 16'h0});
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle", {30'd0, busy, done}, 32'd0);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          run(a, b, c, 1'b0, 1'b0);
          run(a, b, c, 1'b1, 1'b0);
        end
    run(0, 0, 0, 1'b0, 1'b1);
    run(1, 2, 1, 1'b1, 1'b1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule